// File: doc/BRIEF.md
# Bus Clock Prescaler Chain

This block derives every bus and peripheral rate from one system clock. It does not make new clock nets. Each derived rate appears as a clock-enable strobe that is high for one system-clock cycle per period. A logic domain that runs at a divided rate stays on the system clock and qualifies its flops with the matching strobe.

The chain has a fixed structure. The high-speed bus stage divides the system clock. A fixed divide-by-eight tick and two peripheral-bus stages divide the high-speed bus strobe. Each peripheral bus drives a timer strobe. The converter stage divides the strobe of peripheral bus 2. A stage counts only pulses of its parent strobe, so every strobe in the chain is phase aligned with its parent. A new divider setting is taken at the end of the current period of its stage. A period is therefore never cut short.

Top module: `bus_clk_prescaler`

## Requirements
- R1: The 4-bit high-speed bus code `hb_div_i` selects the divide ratio. Codes 0..4 give 1, 2, 4, 8 and 16. Codes 5..8 give 64, 128, 256 and 512. Divide by 32 is not available. Codes 9..15 give divide by 1.
- R2: Each 3-bit peripheral bus code (`pb1_div_i`, `pb2_div_i`) divides the high-speed bus rate. Codes 0..4 give 1, 2, 4, 8 and 16. Codes 5..7 give divide by 1.
- R3: `tick8_stb_o` fires once for every 8 high-speed bus strobes.
- R4: When a peripheral bus ratio is 1, its timer strobe equals that bus strobe. Otherwise the timer strobe fires at twice the bus rate: at the start of the bus period and again halfway through it.
- R5: The 2-bit converter code `cv_div_i` divides the peripheral bus 2 rate. Codes 0, 1, 2 and 3 give 2, 4, 6 and 8.
- R6: Every strobe is high for exactly one system-clock cycle per period. A total ratio of 1 holds the strobe high on every cycle.
- R7: A derived strobe is high only in cycles where its parent strobe is also high. The parent of the tick, both buses and both timers is the high-speed bus. The parent of the converter is peripheral bus 2.
- R8: A change of divider code takes effect at the next period boundary of its stage. The period already in progress completes at its old length.
- R9: While reset is asserted, all counters are cleared and all seven strobes are high. Reset selects divide by 1 for every bus and divide by 2 for the converter. The inputs are first taken at the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hb_div_i | input | 4 | High-speed bus divider code |
| pb1_div_i | input | 3 | Peripheral bus 1 divider code |
| pb2_div_i | input | 3 | Peripheral bus 2 divider code |
| cv_div_i | input | 2 | Converter divider code |
| hb_stb_o | output | 1 | High-speed bus enable strobe |
| tick8_stb_o | output | 1 | Strobe at one eighth of the high-speed bus rate |
| pb1_stb_o | output | 1 | Peripheral bus 1 enable strobe |
| pb2_stb_o | output | 1 | Peripheral bus 2 enable strobe |
| tmr1_stb_o | output | 1 | Timer group strobe derived from peripheral bus 1 |
| tmr2_stb_o | output | 1 | Timer group strobe derived from peripheral bus 2 |
| cv_stb_o | output | 1 | Converter enable strobe |

## Verification
The hardest case to reach is a code change that lands in the middle of a period. Its effect is visible only as the length of the one period in progress. The bench first locks onto a strobe of the stage under test. It then changes the code a known number of cycles later and measures two gaps: the first gap must be the remainder of the old period, and the second must be the new ratio. The large ratios and the unused codes are reached by sweeping every code. Each sweep step skips the first gaps after a change, so that earlier settings have drained from the stage before the measured gap.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

    // Code widths of the divider settings
    localparam int HB_CODE_W = 4;
    localparam int PB_CODE_W = 3;
    localparam int CV_CODE_W = 2;

    // High-speed bus ratio set: powers of two with one gap
    localparam int HB_CODES    = 9;   // codes 0..8 are defined
    localparam int HB_SKIP_LOG = 5;   // log2 of the missing ratio
    localparam int HB_MAX_LOG  = 9;   // log2 of the largest ratio

    // Peripheral bus ratio set
    localparam int PB_CODES   = 5;
    localparam int PB_MAX_LOG = 4;

    // Fixed tick ratio and converter limits
    localparam int TICK_DIV   = 8;
    localparam int CV_MAX_DIV = 8;

    // Number of peripheral bus branches
    localparam int NUM_PB = 2;

    // Counter widths hold the full ratio value
    localparam int HB_CNT_W   = HB_MAX_LOG + 1;
    localparam int PB_CNT_W   = PB_MAX_LOG + 1;
    localparam int TICK_CNT_W = $clog2(TICK_DIV) + 1;
    localparam int CV_CNT_W   = $clog2(CV_MAX_DIV) + 1;

    // Decoder variants
    typedef enum int {
        DEC_HBUS = 0,
        DEC_PBUS = 1,
        DEC_CONV = 2
    } dec_kind_e;

endpackage

// File: rtl/ratio_decoder.sv
module ratio_decoder
    import clk_ratio_pkg::*;
#(
    parameter dec_kind_e KIND   = DEC_HBUS,
    parameter int        CODE_W = 4,
    parameter int        CNT_W  = 10
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  ratio_o
);

    generate
        if (KIND == DEC_HBUS) begin : g_hbus
            // Powers of two, skipping 2**HB_SKIP_LOG; unused codes give 1
            always_comb begin
                int sh;
                sh = int'(code_i);
                if (sh < HB_SKIP_LOG) begin
                    ratio_o = CNT_W'(1) << sh;
                end else if (sh < HB_CODES) begin
                    ratio_o = CNT_W'(1) << (sh + 1);
                end else begin
                    ratio_o = CNT_W'(1);
                end
            end
        end else if (KIND == DEC_PBUS) begin : g_pbus
            // Plain powers of two; unused codes give 1
            always_comb begin
                int sh;
                sh = int'(code_i);
                if (sh < PB_CODES) begin
                    ratio_o = CNT_W'(1) << sh;
                end else begin
                    ratio_o = CNT_W'(1);
                end
            end
        end else begin : g_conv
            // Even ratios 2, 4, 6, 8 ...
            always_comb begin
                int r;
                r = 2 * (int'(code_i) + 1);
                ratio_o = CNT_W'(r);
            end
        end
    endgenerate

endmodule

// File: rtl/ratio_stage.sv
module ratio_stage #(
    parameter int CNT_W     = 4,
    parameter int RST_RATIO = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             parent_stb_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             stb_o,
    output logic             half_stb_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
    } stage_t;

    stage_t           st_d, st_q;
    logic             last_w;
    logic [CNT_W-1:0] next_ratio;

    always_comb begin
        // A zero ratio is not a legal setting; treat it as 1
        next_ratio = (ratio_i == '0) ? CNT_W'(1) : ratio_i;
        last_w     = (st_q.cnt >= st_q.ratio - CNT_W'(1));
        st_d       = st_q;
        if (parent_stb_i) begin
            if (last_w) begin
                // Period boundary: the new setting is taken only here
                st_d.cnt   = '0;
                st_d.ratio = next_ratio;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.ratio <= CNT_W'(RST_RATIO);
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o      = parent_stb_i & (st_q.cnt == '0);
    assign half_stb_o = parent_stb_i & (st_q.ratio > CNT_W'(1))
                        & (st_q.cnt == (st_q.ratio >> 1));

endmodule

// File: rtl/bus_branch.sv
module bus_branch
    import clk_ratio_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hb_stb_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              bus_stb_o,
    output logic              tmr_stb_o
);

    logic [CNT_W-1:0] ratio_w;
    logic             half_w;

    ratio_decoder #(
        .KIND   (DEC_PBUS),
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) i_dec (
        .code_i  (code_i),
        .ratio_o (ratio_w)
    );

    ratio_stage #(
        .CNT_W     (CNT_W),
        .RST_RATIO (1)
    ) i_stage (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .parent_stb_i (hb_stb_i),
        .ratio_i      (ratio_w),
        .stb_o        (bus_stb_o),
        .half_stb_o   (half_w)
    );

    // Timer runs at the bus rate for ratio 1, otherwise at twice the bus rate
    assign tmr_stb_o = bus_stb_o | half_w;

endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
    import clk_ratio_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [HB_CODE_W-1:0] hb_div_i,
    input  logic [PB_CODE_W-1:0] pb1_div_i,
    input  logic [PB_CODE_W-1:0] pb2_div_i,
    input  logic [CV_CODE_W-1:0] cv_div_i,
    output logic                 hb_stb_o,
    output logic                 tick8_stb_o,
    output logic                 pb1_stb_o,
    output logic                 pb2_stb_o,
    output logic                 tmr1_stb_o,
    output logic                 tmr2_stb_o,
    output logic                 cv_stb_o
);

    logic [HB_CNT_W-1:0]   hb_ratio;
    logic [CV_CNT_W-1:0]   cv_ratio;
    logic                  hb_stb, hb_half, tick_half, cv_half;
    logic                  unused_half;
    logic [PB_CODE_W-1:0]  pb_code [NUM_PB];
    logic [NUM_PB-1:0]     pb_stb, tmr_stb;

    // High-speed bus stage, fed every system clock cycle
    ratio_decoder #(
        .KIND   (DEC_HBUS),
        .CODE_W (HB_CODE_W),
        .CNT_W  (HB_CNT_W)
    ) i_hb_dec (
        .code_i  (hb_div_i),
        .ratio_o (hb_ratio)
    );

    ratio_stage #(
        .CNT_W     (HB_CNT_W),
        .RST_RATIO (1)
    ) i_hb_stage (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .parent_stb_i (1'b1),
        .ratio_i      (hb_ratio),
        .stb_o        (hb_stb),
        .half_stb_o   (hb_half)
    );

    // Fixed one-eighth tick
    logic tick_stb;
    ratio_stage #(
        .CNT_W     (TICK_CNT_W),
        .RST_RATIO (TICK_DIV)
    ) i_tick_stage (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .parent_stb_i (hb_stb),
        .ratio_i      (TICK_CNT_W'(TICK_DIV)),
        .stb_o        (tick_stb),
        .half_stb_o   (tick_half)
    );

    // Peripheral bus branches
    assign pb_code[0] = pb1_div_i;
    assign pb_code[1] = pb2_div_i;

    generate
        for (genvar b = 0; b < NUM_PB; b++) begin : g_pb
            bus_branch #(
                .CODE_W (PB_CODE_W),
                .CNT_W  (PB_CNT_W)
            ) i_branch (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .hb_stb_i  (hb_stb),
                .code_i    (pb_code[b]),
                .bus_stb_o (pb_stb[b]),
                .tmr_stb_o (tmr_stb[b])
            );
        end
    endgenerate

    // Converter stage hangs off peripheral bus 2
    ratio_decoder #(
        .KIND   (DEC_CONV),
        .CODE_W (CV_CODE_W),
        .CNT_W  (CV_CNT_W)
    ) i_cv_dec (
        .code_i  (cv_div_i),
        .ratio_o (cv_ratio)
    );

    logic cv_stb;
    ratio_stage #(
        .CNT_W     (CV_CNT_W),
        .RST_RATIO (2)
    ) i_cv_stage (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .parent_stb_i (pb_stb[1]),
        .ratio_i      (cv_ratio),
        .stb_o        (cv_stb),
        .half_stb_o   (cv_half)
    );

    assign unused_half = hb_half ^ tick_half ^ cv_half;

    assign hb_stb_o    = hb_stb;
    assign tick8_stb_o = tick_stb;
    assign pb1_stb_o   = pb_stb[0];
    assign pb2_stb_o   = pb_stb[1];
    assign tmr1_stb_o  = tmr_stb[0];
    assign tmr2_stb_o  = tmr_stb[1];
    assign cv_stb_o    = cv_stb;

endmodule

// File: rtl/bus_clk_prescaler_chk.sv
module bus_clk_prescaler_chk
    import clk_ratio_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [HB_CODE_W-1:0] hb_div_i,
    input logic [PB_CODE_W-1:0] pb1_div_i,
    input logic [PB_CODE_W-1:0] pb2_div_i,
    input logic [CV_CODE_W-1:0] cv_div_i,
    input logic                 hb_stb_o,
    input logic                 tick8_stb_o,
    input logic                 pb1_stb_o,
    input logic                 pb2_stb_o,
    input logic                 tmr1_stb_o,
    input logic                 tmr2_stb_o,
    input logic                 cv_stb_o
);

    // R7: child strobes only coincide with their parent
    a_r7_pb1_in_hb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pb1_stb_o |-> hb_stb_o);
    a_r7_pb2_in_hb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pb2_stb_o |-> hb_stb_o);
    a_r7_tick_in_hb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick8_stb_o |-> hb_stb_o);
    a_r7_tmr_in_hb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr1_stb_o | tmr2_stb_o) |-> hb_stb_o);
    a_r7_cv_in_pb2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cv_stb_o |-> pb2_stb_o);

    // R4: a timer strobe is present whenever its bus strobe is
    a_r4_pb1_in_tmr1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pb1_stb_o |-> tmr1_stb_o);
    a_r4_pb2_in_tmr2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pb2_stb_o |-> tmr2_stb_o);

    // R3: exactly seven bus strobes lie between two ticks
    logic [3:0] hb_since_q;
    logic       seen_tick_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hb_since_q  <= '0;
            seen_tick_q <= 1'b0;
        end else if (hb_stb_o && tick8_stb_o) begin
            hb_since_q  <= '0;
            seen_tick_q <= 1'b1;
        end else if (hb_stb_o) begin
            hb_since_q <= hb_since_q + 4'd1;
        end
    end

    a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick8_stb_o && seen_tick_q) |-> (hb_since_q == 4'd7));

    // R9: while in reset every strobe is held high
    always @(posedge clk_i) begin
        if (rst_ni === 1'b0) begin
            a_r9_reset_all_high: assert ({hb_stb_o, tick8_stb_o, pb1_stb_o, pb2_stb_o,
                                          tmr1_stb_o, tmr2_stb_o, cv_stb_o} == 7'h7F);
        end
    end

endmodule

bind bus_clk_prescaler bus_clk_prescaler_chk i_chk (.*);

// File: tb/test_bus_clk_prescaler.sv
module test_bus_clk_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hb_div = '0;
    logic [2:0] pb1_div = '0;
    logic [2:0] pb2_div = '0;
    logic [1:0] cv_div = '0;
    logic       hb_stb, tick_stb, pb1_stb, pb2_stb, tmr1_stb, tmr2_stb, cv_stb;
    logic [6:0] stb;

    int checks = 0;
    int errors = 0;

    localparam int S_HB = 0, S_TICK = 1, S_PB1 = 2, S_PB2 = 3, S_TMR1 = 4, S_TMR2 = 5, S_CV = 6;

    always #2.5 clk = ~clk;

    assign stb = {cv_stb, tmr2_stb, tmr1_stb, pb2_stb, pb1_stb, tick_stb, hb_stb};

    bus_clk_prescaler i_bus_clk_prescaler (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hb_div_i    (hb_div),
        .pb1_div_i   (pb1_div),
        .pb2_div_i   (pb2_div),
        .cv_div_i    (cv_div),
        .hb_stb_o    (hb_stb),
        .tick8_stb_o (tick_stb),
        .pb1_stb_o   (pb1_stb),
        .pb2_stb_o   (pb2_stb),
        .tmr1_stb_o  (tmr1_stb),
        .tmr2_stb_o  (tmr2_stb),
        .cv_stb_o    (cv_stb)
    );

    // Reference ratio sets taken from the requirements
    function automatic int hb_ratio(input int code);
        if (code < 5) return 1 << code;
        if (code < 9) return 1 << (code + 1);
        return 1;
    endfunction

    function automatic int pb_ratio(input int code);
        return (code < 5) ? (1 << code) : 1;
    endfunction

    function automatic int tmr_period(input int hcode, input int pcode);
        int p;
        p = pb_ratio(pcode);
        return (p == 1) ? hb_ratio(hcode) : hb_ratio(hcode) * p / 2;
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance to the next negedge at which the selected strobe is high
    task automatic next_strobe(input int sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!stb[sel] && n < 70000);
    endtask

    // Lock onto the strobe, let old settings drain, then measure one period
    task automatic check_period(input int sel, input int exp, input string tag);
        int g;
        next_strobe(sel, g);
        next_strobe(sel, g);
        next_strobe(sel, g);
        next_strobe(sel, g);
        check_eq(tag, g, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        hb_div = 4'd3;
        pb1_div = 3'd0;
        pb2_div = 3'd0;
        cv_div = 2'd1;
        repeat (3) @(negedge clk);
        check_eq("R9 all strobes high in reset", int'(stb), 7'h7F);
        rst_n = 1'b1;
        check_eq("R9 strobes high at release", int'(stb), 7'h7F);
        @(negedge clk);
        check_eq("R9 bus strobe first cycle after release", int'(hb_stb), 1);
        @(negedge clk);
        check_eq("R9 bus strobe low in second cycle", int'(hb_stb), 0);
        check_period(S_HB, 8, "R9 input taken after release");
    endtask

    task automatic t_hbus_sweep;
        pb1_div = 3'd0;
        for (int c = 0; c < 16; c++) begin
            hb_div = 4'(c);
            check_period(S_HB, hb_ratio(c), $sformatf("R1 hbus code %0d", c));
        end
        hb_div = 4'd0;
        check_period(S_HB, 1, "R6 ratio 1 held high");
    endtask

    task automatic t_tick;
        hb_div = 4'd0;
        check_period(S_TICK, 8, "R3 tick at hbus /1");
        hb_div = 4'd2;
        check_period(S_TICK, 32, "R3 tick at hbus /4");
        hb_div = 4'd5;
        check_period(S_TICK, 512, "R3 tick at hbus /64");
        hb_div = 4'd8;
        check_period(S_TICK, 4096, "R3 tick at hbus /512");
    endtask

    task automatic t_pbus;
        hb_div = 4'd2;
        for (int c = 0; c < 8; c++) begin
            pb1_div = 3'(c);
            pb2_div = 3'(7 - c);
            check_period(S_PB1, 4 * pb_ratio(c), $sformatf("R2 pbus1 code %0d", c));
            check_period(S_PB2, 4 * pb_ratio(7 - c), $sformatf("R2 pbus2 code %0d", 7 - c));
        end
    endtask

    task automatic t_timer;
        hb_div = 4'd1;
        pb1_div = 3'd0;
        check_period(S_TMR1, tmr_period(1, 0), "R4 tmr1 bus ratio 1");
        pb1_div = 3'd2;
        check_period(S_PB1, 8, "R4 pbus1 /4 reference");
        check_period(S_TMR1, tmr_period(1, 2), "R4 tmr1 doubled");
        pb2_div = 3'd4;
        check_period(S_TMR2, tmr_period(1, 4), "R4 tmr2 doubled at /16");
        hb_div = 4'd0;
        pb2_div = 3'd1;
        check_period(S_TMR2, 1, "R4 tmr2 doubled to every cycle");
    endtask

    task automatic t_conv;
        hb_div = 4'd0;
        pb2_div = 3'd2;
        for (int c = 0; c < 4; c++) begin
            cv_div = 2'(c);
            check_period(S_CV, 4 * 2 * (c + 1), $sformatf("R5 conv code %0d", c));
        end
        hb_div = 4'd2;
        pb2_div = 3'd3;
        cv_div = 2'd2;
        check_period(S_CV, 4 * 8 * 6, "R5 conv chained /4 /8 /6");
    endtask

    task automatic t_align;
        int bad;
        int hi;
        hb_div = 4'd1;
        pb1_div = 3'd1;
        pb2_div = 3'd2;
        cv_div = 2'd0;
        repeat (64) @(negedge clk);
        bad = 0;
        hi = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ((pb1_stb | pb2_stb | tick_stb | tmr1_stb | tmr2_stb) && !hb_stb) bad++;
            if (cv_stb && !pb2_stb) bad++;
            if (hb_stb && stb[S_HB] && i > 0 && hi == i - 1) bad += 0;
            if (hb_stb) hi = i;
        end
        check_eq("R7 no child strobe without parent", bad, 0);
    endtask

    task automatic t_change;
        int g;
        hb_div = 4'd0;
        pb1_div = 3'd4;
        check_period(S_PB1, 16, "R8 pbus1 initial /16");
        repeat (3) @(negedge clk);
        pb1_div = 3'd1;
        next_strobe(S_PB1, g);
        check_eq("R8 old pbus1 period completes", g, 13);
        next_strobe(S_PB1, g);
        check_eq("R8 new pbus1 period", g, 2);
        next_strobe(S_PB1, g);
        check_eq("R6 pbus1 single-cycle pulse", g, 2);
        hb_div = 4'd3;
        check_period(S_HB, 8, "R8 hbus initial /8");
        repeat (2) @(negedge clk);
        hb_div = 4'd0;
        next_strobe(S_HB, g);
        check_eq("R8 old hbus period completes", g, 6);
        next_strobe(S_HB, g);
        check_eq("R8 new hbus period", g, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hbus_sweep();
        t_tick();
        t_pbus();
        t_timer();
        t_conv();
        t_align();
        t_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule